// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a target FPGA through its slave-serial configuration pins. A start pulse opens the program pulse. The block holds the program line low until the target pulls its init line low. It then releases program and waits for init to come back high. Each of these waits is bounded by a timeout.

Once the target is ready, the block takes bytes from a valid/ready stream. It discards bytes until it sees four 0xFF bytes in a row. From there it sends the preamble, every later byte and a trailer of 0xFF bytes. Each bit goes out most significant bit first on a registered clock/data pin pair. After the trailer the block waits, again under a timeout, for the done line to rise. It then gives a one-cycle finish pulse with a two-bit result code.

Poll interval, poll limit, bit-phase length, preamble length and trailer length are parameters. A test build can therefore use short intervals. Decompression and header parsing belong to other blocks.

Top module: `fpga_serial_loader`

## Requirements
- R1: A start pulse while idle drives prog_o low with cclk_o and cdata_o high. This holds until the synchronised init input is seen low.
- R2: The init level is checked on entry to each wait and then once every POLL_CYCLES cycles. If init is still high at the check taken after MAX_POLLS+1 intervals, the run ends with result 1 (init never fell).
- R3: When init has fallen, prog_o returns high and the block waits for init to rise under the same limit. On expiry the result is 2 (init never rose).
- R4: Bytes are discarded until PRE_LEN consecutive 0xFF bytes arrive. Those preamble bytes are the first bytes sent, and every accepted byte after them follows in order.
- R5: Each byte is sent most significant bit first, one bit per rising edge of cclk_o.
- R6: Each bit takes four pin updates of STEP_CYCLES cycles each: clock low with data high, data set to the bit, clock high, data back high. Data never changes on a rising clock edge.
- R7: After the byte that carries in_last, TRAIL_BYTES bytes of 0xFF are sent.
- R8: After the trailer, done is polled like init. If done is seen high the result is 0 (success). Otherwise the result is 3 (done timeout).
- R9: Every run ends with a single-cycle fin_o pulse and a return to idle with prog_o high. While idle, in_ready stays low and stream bytes are ignored until the next start.
- R10: After reset, prog_o, cclk_o and cdata_o are high, busy_o, fin_o and in_ready are low, and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| in_data | input | 8 | Configuration stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_last | input | 1 | Marks the final stream byte |
| in_ready | output | 1 | Block accepts a stream byte this cycle |
| init_pin_i | input | 1 | Target init line (asynchronous) |
| done_pin_i | input | 1 | Target done line (asynchronous) |
| prog_o | output | 1 | Target program line, active low |
| cclk_o | output | 1 | Configuration clock |
| cdata_o | output | 1 | Configuration data |
| busy_o | output | 1 | A run is in progress |
| fin_o | output | 1 | One-cycle pulse at the end of a run |
| result_o | output | 2 | 0 ok, 1 init never fell, 2 init never rose, 3 done timeout |

## Verification
The checker assumes that start_i, the stream inputs and the target pins are driven from the block's own clock domain or through its synchronisers. It also assumes that the stream offers a byte only as a whole byte with its last flag. The bench drives every input half a period away from the sampling edge. It models the target with delayed init and done responses, so that init moves only in reaction to prog_o, well inside one poll interval. The junk before the preamble never holds four 0xFF bytes in a row and always ends in 0x00. This means the place where the bench expects the preamble is exactly where the block must find it.

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader #(
  parameter int POLL_CYCLES = 100000,
  parameter int MAX_POLLS   = 3,
  parameter int STEP_CYCLES = 4,
  parameter int PRE_LEN     = 4,
  parameter int TRAIL_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       init_pin_i,
  input  logic       done_pin_i,
  output logic       prog_o,
  output logic       cclk_o,
  output logic       cdata_o,
  output logic       busy_o,
  output logic       fin_o,
  output logic [1:0] result_o
);
  localparam int PW = $clog2(POLL_CYCLES + 1);
  localparam int NW = $clog2(MAX_POLLS + 2);
  localparam int SW = $clog2(STEP_CYCLES + 1);
  localparam int FW = $clog2(PRE_LEN + TRAIL_BYTES + 1);
  localparam int RW = $clog2(PRE_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_REL, S_SEEK, S_FETCH, S_SHIFT, S_DONE} st_t;
  st_t st;

  logic [1:0]    init_s, done_s;
  logic [PW-1:0] cyc;
  logic [NW-1:0] polls;
  logic [SW-1:0] sc;
  logic [FW-1:0] fill;
  logic [RW-1:0] run;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic [1:0]    ph;
  logic          last_seen, trailed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      init_s <= '0;
      done_s <= '0;
    end else begin
      init_s <= {init_s[0], init_pin_i};
      done_s <= {done_s[0], done_pin_i};
    end

  wire cond = (st == S_PROG) ? !init_s[1] :
              (st == S_REL)  ?  init_s[1] : done_s[1];
  wire expired = polls == NW'(MAX_POLLS + 1);
  wire [1:0] fail_code = (st == S_PROG) ? 2'd1 : (st == S_REL) ? 2'd2 : 2'd3;

  assign in_ready = (st == S_SEEK) || (st == S_FETCH);
  assign busy_o   = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      prog_o <= 1'b1;
      cclk_o <= 1'b1;
      cdata_o <= 1'b1;
      fin_o <= 1'b0;
      result_o <= 2'd0;
      cyc <= '0;
      polls <= '0;
      sc <= '0;
      fill <= '0;
      run <= '0;
      sh <= '0;
      bitn <= '0;
      ph <= '0;
      last_seen <= 1'b0;
      trailed <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st <= S_PROG;
          prog_o <= 1'b0;
          cclk_o <= 1'b1;
          cdata_o <= 1'b1;
          cyc <= '0;
          polls <= '0;
          result_o <= 2'd0;
        end
        S_PROG, S_REL, S_DONE: begin
          if (cyc != '0) cyc <= cyc - 1'b1;
          else if (cond) begin
            polls <= '0;
            if (st == S_PROG) begin
              st <= S_REL;
              prog_o <= 1'b1;
            end else if (st == S_REL) begin
              st <= S_SEEK;
              run <= '0;
              last_seen <= 1'b0;
              trailed <= 1'b0;
            end else begin
              st <= S_IDLE;
              fin_o <= 1'b1;
              result_o <= 2'd0;
            end
          end else if (expired) begin
            st <= S_IDLE;
            prog_o <= 1'b1;
            fin_o <= 1'b1;
            result_o <= fail_code;
          end else begin
            polls <= polls + 1'b1;
            cyc <= PW'(POLL_CYCLES - 1);
          end
        end
        S_SEEK: if (in_valid) begin
          if (in_data != 8'hFF) run <= '0;
          else if (run != RW'(PRE_LEN - 1)) run <= run + 1'b1;
          else begin
            sh <= 8'hFF;
            fill <= FW'(PRE_LEN - 1);
            last_seen <= in_last;
            bitn <= '0;
            ph <= '0;
            sc <= SW'(STEP_CYCLES - 1);
            cclk_o <= 1'b0;
            cdata_o <= 1'b1;
            st <= S_SHIFT;
          end
        end
        S_FETCH: if (in_valid) begin
          sh <= in_data;
          last_seen <= in_last;
          bitn <= '0;
          ph <= '0;
          sc <= SW'(STEP_CYCLES - 1);
          cclk_o <= 1'b0;
          cdata_o <= 1'b1;
          st <= S_SHIFT;
        end
        S_SHIFT: begin
          if (sc != '0) sc <= sc - 1'b1;
          else begin
            sc <= SW'(STEP_CYCLES - 1);
            ph <= ph + 1'b1;
            case (ph)
              2'd0: cdata_o <= sh[7];
              2'd1: cclk_o <= 1'b1;
              2'd2: cdata_o <= 1'b1;
              default: begin
                sh <= {sh[6:0], 1'b0};
                bitn <= bitn + 1'b1;
                if (bitn != 3'd7) cclk_o <= 1'b0;
                else if (fill != '0) begin
                  fill <= fill - 1'b1;
                  sh <= 8'hFF;
                  cclk_o <= 1'b0;
                end else if (last_seen && !trailed) begin
                  trailed <= 1'b1;
                  fill <= FW'(TRAIL_BYTES - 1);
                  sh <= 8'hFF;
                  cclk_o <= 1'b0;
                end else if (last_seen) begin
                  st <= S_DONE;
                  cyc <= '0;
                  polls <= '0;
                end else st <= S_FETCH;
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
endmodule

module fpga_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic in_ready,
  input logic prog_o,
  input logic cclk_o,
  input logic cdata_o,
  input logic busy_o,
  input logic fin_o
);
  // R1
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_o |-> (cclk_o && cdata_o));
  // R1
  start_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> !prog_o);
  // R6
  fall_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk_o) |-> cdata_o);
  // R6
  rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(cdata_o));
  // R9
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);
  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy_o && prog_o));
  // R9
  idle_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> prog_o);
endmodule

bind fpga_serial_loader fpga_serial_loader_chk chk_i (.*);

// File: tb/fpga_serial_loader_tb_top.sv
module fpga_serial_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POLL = 20;
  localparam int MAXP = 3;
  localparam int STEP = 2;
  localparam int PRE = 4;
  localparam int TRAIL = 8;
  localparam int NVEC = 6;
  // {target mode, payload bytes, junk bytes, expected result}
  // mode 0 normal, 1 init stuck high, 2 init stuck low, 3 done never rises
  localparam logic [19:0] VEC [0:NVEC-1] = '{
    {2'd0, 8'd5,  8'd3, 2'd0},
    {2'd0, 8'd1,  8'd0, 2'd0},
    {2'd0, 8'd12, 8'd7, 2'd0},
    {2'd3, 8'd3,  8'd2, 2'd3},
    {2'd1, 8'd0,  8'd0, 2'd1},
    {2'd2, 8'd0,  8'd0, 2'd2}
  };

  logic clk = 0, rst_n = 0, start_i = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, in_last = 0;
  logic in_ready, prog_o, cclk_o, cdata_o, busy_o, fin_o;
  logic [1:0] result_o;
  logic init_pin = 1, done_pin = 0;
  logic [1:0] mode_r = 0;
  logic cap_clr = 1, cclk_d = 1;
  logic [7:0] cap [0:63];
  int cap_bits = 0, exp_bits = 0, dly = 0, cycles = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpga_serial_loader #(.POLL_CYCLES(POLL), .MAX_POLLS(MAXP), .STEP_CYCLES(STEP),
    .PRE_LEN(PRE), .TRAIL_BYTES(TRAIL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .init_pin_i(init_pin), .done_pin_i(done_pin), .prog_o(prog_o),
    .cclk_o(cclk_o), .cdata_o(cdata_o), .busy_o(busy_o), .fin_o(fin_o),
    .result_o(result_o));

  always @(posedge clk) begin
    cclk_d <= cclk_o;
    if (cap_clr) cap_bits <= 0;
    else if (cclk_o && !cclk_d && cap_bits < 512) begin
      cap[cap_bits >> 3] <= {cap[cap_bits >> 3][6:0], cdata_o};
      cap_bits <= cap_bits + 1;
    end
    if (!prog_o) done_pin <= 0;
    else if (mode_r != 2'd3 && exp_bits > 0 && cap_bits >= exp_bits) done_pin <= 1;
  end

  always @(posedge clk) begin
    case (mode_r)
      2'd1: init_pin <= 1;
      2'd2: if (!prog_o) init_pin <= 0;
      default:
        if (!prog_o) begin init_pin <= 0; dly <= 0; end
        else if (!init_pin) begin
          dly <= dly + 1;
          if (dly == 5) init_pin <= 1;
        end
    endcase
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int i, input int s);
    return 8'(i * 53 + s * 17 + 1);
  endfunction

  task automatic send(input logic [7:0] d, input logic l);
    bit hs;
    in_data = d; in_last = l; in_valid = 1;
    forever begin
      hs = in_ready;
      @(negedge clk);
      if (hs) break;
    end
    in_valid = 0; in_last = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(prog_o && cclk_o && cdata_o, "R10 pins", {prog_o, cclk_o, cdata_o}, 7);
    chk(!busy_o && !fin_o && !in_ready && result_o == 0, "R10 status",
        {busy_o, fin_o, in_ready, result_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(prog_o && !busy_o, "R10 after release", {prog_o, busy_o}, 2);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] md, ec;
      int n, lead, t0, nb, got;
      bit seen;
      {md, n, lead, ec} = {VEC[v][19:18], int'(VEC[v][17:10]), int'(VEC[v][9:2]), VEC[v][1:0]};
      mode_r = md;
      cap_clr = 1;
      exp_bits = (PRE + n + TRAIL) * 8;
      repeat (2) @(negedge clk);
      cap_clr = 0;
      start_i = 1; t0 = cycles;
      @(negedge clk);
      start_i = 0;
      // R1 program pulse with clock and data high
      chk(!prog_o && cclk_o && cdata_o && busy_o, "R1 program pulse",
          {prog_o, cclk_o, cdata_o, busy_o}, 7);
      if (md == 2'd0 || md == 2'd3) begin
        for (int j = 0; j < lead; j++)
          send(((lead - 1 - j) % 3 == 0) ? 8'h00 : 8'hFF, 1'b0);
        for (int j = 0; j < PRE; j++) send(8'hFF, 1'b0);
        for (int j = 0; j < n; j++) send(pay(j, v), j == n - 1);
      end
      seen = 0;
      for (int k = 0; k < 20000 && !seen; k++) begin
        @(negedge clk);
        if (fin_o) seen = 1;
      end
      got = cycles - t0;
      chk(seen, "R9 fin pulse seen", seen, 1);
      chk(result_o == ec, (ec == 0) ? "R8 success code" : (ec == 1) ? "R2 init high code" :
          (ec == 2) ? "R3 init low code" : "R8 done timeout code", result_o, ec);
      if (ec == 2'd1)
        chk(got >= (MAXP + 1) * POLL && got <= (MAXP + 1) * POLL + 10,
            "R2 timeout window", got, (MAXP + 1) * POLL);
      if (md == 2'd0 || md == 2'd3) begin
        nb = cap_bits / 8;
        chk(cap_bits == exp_bits, "R7 total bits incl trailer", cap_bits, exp_bits);
        for (int k = 0; k < nb && k < 64; k++) begin
          logic [7:0] e;
          e = (k < PRE) ? 8'hFF : (k < PRE + n) ? pay(k - PRE, v) : 8'hFF;
          chk(cap[k] == e, (k < PRE) ? "R4 preamble byte" : (k < PRE + n) ? "R5 data byte" :
              "R7 trailer byte", cap[k], e);
        end
      end
      @(negedge clk);
      chk(!fin_o, "R9 fin single cycle", fin_o, 0);
      chk(prog_o && !busy_o && !in_ready, "R9 idle after run", {prog_o, busy_o, in_ready}, 4);
      if (ec != 2'd0) begin
        int b0;
        bit rdy;
        b0 = cap_bits; rdy = 0;
        in_data = 8'hFF; in_valid = 1; in_last = 1;
        repeat (40) begin
          @(negedge clk);
          if (in_ready || !prog_o || busy_o) rdy = 1;
        end
        in_valid = 0; in_last = 0;
        chk(!rdy && cap_bits == b0, "R9 bytes ignored after failure", cap_bits, b0);
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule